// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block turns a single PHY register request (PHY number, page, register index, direction and write data) into the chain of switch register transactions that reaches a PHY register hidden behind an indirect access window. It validates the arguments and builds the encoded window address. It then drives the transactions one at a time on a request/done/error port towards a two-wire register master. At the end it reports the read data and an error flag together with a one-cycle completion pulse.

A mode input selects how results are presented. In raw mode the caller supplies the page, a write ends after its second transaction, and a failed read returns zero. In PHY-bus mode the page is forced to zero, a failed read returns all ones, and every write is followed by a full read of the same register to flush it. The read data from that flush is discarded, and the write's own status is what gets reported.

The sequencer has these states. IDLE waits for a request. CTRL writes the access-control register. ADDR writes the encoded address. DATA reads the access-data register. DONE raises the completion pulse. The transitions are:
- IDLE to CTRL when the arguments pass the range check.
- IDLE to DONE when they fail it.
- CTRL to ADDR after a clean completion.
- ADDR to DATA for a read.
- ADDR to DONE for a raw write.
- ADDR back to CTRL to start the flush pass of a PHY-bus write.
- DATA to DONE.
- Any bus state to DONE, or to CTRL for the flush pass, on an error.
- DONE to IDLE.

Top module: `phy_indirect_seq`

## Requirements
- R1: A request whose PHY number exceeds 4, whose register index exceeds 31, or (raw mode only) whose page exceeds 7 issues no bus transaction; `done` pulses in the cycle after acceptance with `err`=1, and `rdata` is 0xFFFF for a PHY-bus read, otherwise 0.
- R2: The first transaction of every pass is a write to 0x8028 whose data is 1 for a read pass and 0 for a write pass.
- R3: The second transaction is a write to 0x8000 | (1 << (phy+9)) | (page << 5) | reg, carrying the write data for a write pass and 0 for a read pass.
- R4: A read pass ends with a read of 0x8029; without error its data is returned on `rdata` with `err`=0.
- R5: An error on any transaction ends the current pass at once: no further transaction of that pass is issued and `err` is set.
- R6: A failed read returns `rdata`=0xFFFF in PHY-bus mode and 0 in raw mode.
- R7: In PHY-bus mode a write, failed or not, is followed by a full read pass (three transactions) to the same register. The flush data is dropped, a flush error is ignored, and `err` reflects only the write. A raw write issues exactly two transactions.
- R8: In PHY-bus mode the page input is ignored: it is encoded as 0 and never range-checked.
- R9: Address, data and direction stay stable while `bus_req` is high until `bus_done`; `req_valid` is ignored while `busy` is high.
- R10: `busy` is high from acceptance until the `done` cycle. `done` is a single-cycle pulse that marks the end of the whole sequence, including any flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus_mode | input | 1 | 1 = PHY-bus mode, 0 = raw mode |
| req_phy | input | 5 | PHY number |
| req_page | input | 4 | Page (raw mode) |
| req_reg | input | 6 | Register index |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Result error flag, valid with done |
| rdata | output | 16 | Read result, valid with done |
| bus_req | output | 1 | Transaction request, held until bus_done |
| bus_write | output | 1 | Transaction direction |
| bus_addr | output | 16 | Switch register address |
| bus_wdata | output | 16 | Switch register write data |
| bus_done | input | 1 | Transaction complete (one cycle) |
| bus_err | input | 1 | Transaction failed, valid with bus_done |
| bus_rdata | input | 16 | Transaction read data, valid with bus_done |

## Verification
A rejected request raises `done` one cycle after the accepting edge. For an accepted request, each transaction takes the responder's three-cycle latency plus the cycle in which `bus_done` is seen, so `done` is due exactly 4·n+1 cycles after acceptance for n transactions. The bench counts cycles from acceptance to `done` and compares the count with that formula. It samples every output on the falling edge, and it logs each transaction that the model responder completes so that order, address, direction and data can be compared against the expected chain.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_ADDR,
        S_DATA,
        S_DONE
    } seq_state_t;

    localparam logic [15:0] DEF_CTRL_ADDR = 16'h8028;
    localparam logic [15:0] DEF_DATA_ADDR = 16'h8029;
    localparam logic [15:0] DEF_ENC_BASE  = 16'h8000;
endpackage

// File: rtl/phy_req_check.sv
module phy_req_check #(
    parameter int PHY_W    = 5,
    parameter int PAGE_W   = 4,
    parameter int REG_W    = 6,
    parameter int MAX_PHY  = 4,
    parameter int MAX_PAGE = 7,
    parameter int MAX_REG  = 31
) (
    input  logic [PHY_W-1:0]  phy,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  regi,
    input  logic              page_used,
    output logic              ok
);
    logic phy_ok, page_ok, reg_ok;

    always_comb begin
        phy_ok  = (phy <= PHY_W'(MAX_PHY));
        page_ok = !page_used || (page <= PAGE_W'(MAX_PAGE));
        reg_ok  = (regi <= REG_W'(MAX_REG));
        ok      = phy_ok && page_ok && reg_ok;
    end
endmodule

// File: rtl/phy_addr_enc.sv
module phy_addr_enc #(
    parameter int          PHY_W      = 5,
    parameter int          PAGE_W     = 4,
    parameter int          REG_W      = 6,
    parameter int          ADDR_W     = 16,
    parameter int          PHY_SHIFT  = 9,
    parameter int          PAGE_SHIFT = 5,
    parameter int          PAGE_BITS  = 3,
    parameter int          REG_BITS   = 5,
    parameter logic [15:0] ENC_BASE   = 16'h8000
) (
    input  logic [PHY_W-1:0]  phy,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  regi,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] phy_sel, page_fld, reg_fld;

    always_comb begin
        phy_sel  = ADDR_W'(1) << (32'(phy) + PHY_SHIFT);
        page_fld = ADDR_W'(page[PAGE_BITS-1:0]) << PAGE_SHIFT;
        reg_fld  = ADDR_W'(regi[REG_BITS-1:0]);
        addr     = ADDR_W'(ENC_BASE) | phy_sel | page_fld | reg_fld;
    end
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
    import phy_seq_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 16,
    parameter int          PHY_SHIFT = 9,
    parameter int          MAX_PHY   = 4,
    parameter logic [15:0] CTRL_ADDR = 16'h8028,
    parameter logic [15:0] DATA_ADDR = 16'h8029
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_bus_mode,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              arg_ok,
    input  logic [ADDR_W-1:0] enc_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    seq_state_t        st, st_n;
    logic              lat_write, lat_bus, in_flush, flush_n;
    logic [DATA_W-1:0] lat_wdata, rdata_r, rdata_n;
    logic [ADDR_W-1:0] lat_addr;
    logic              err_r, err_n, do_abort, cur_write;

    assign cur_write = lat_write && !in_flush;

    // next-state process
    always_comb begin
        st_n     = st;
        err_n    = err_r;
        rdata_n  = rdata_r;
        flush_n  = in_flush;
        do_abort = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (req_valid) begin
                    flush_n = 1'b0;
                    if (!arg_ok) begin
                        err_n   = 1'b1;
                        rdata_n = (req_bus_mode && !req_write) ? ALL_ONES : '0;
                        st_n    = S_DONE;
                    end else begin
                        err_n   = 1'b0;
                        rdata_n = '0;
                        st_n    = S_CTRL;
                    end
                end
            end
            S_CTRL: begin
                if (bus_done) begin
                    if (bus_err) do_abort = 1'b1;
                    else         st_n = S_ADDR;
                end
            end
            S_ADDR: begin
                if (bus_done) begin
                    if (bus_err) begin
                        do_abort = 1'b1;
                    end else if (cur_write) begin
                        if (lat_bus) begin
                            flush_n = 1'b1;
                            st_n    = S_CTRL;
                        end else begin
                            st_n = S_DONE;
                        end
                    end else begin
                        st_n = S_DATA;
                    end
                end
            end
            S_DATA: begin
                if (bus_done) begin
                    if (in_flush) begin
                        st_n = S_DONE;
                    end else if (bus_err) begin
                        do_abort = 1'b1;
                    end else begin
                        rdata_n = bus_rdata;
                        st_n    = S_DONE;
                    end
                end
            end
            S_DONE:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase

        if (do_abort) begin
            if (in_flush) begin
                st_n = S_DONE;
            end else begin
                err_n = 1'b1;
                if (!lat_write && lat_bus) rdata_n = ALL_ONES;
                if (lat_write && lat_bus) begin
                    flush_n = 1'b1;
                    st_n    = S_CTRL;
                end else begin
                    st_n = S_DONE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            lat_write <= 1'b0;
            lat_bus   <= 1'b0;
            lat_wdata <= '0;
            lat_addr  <= '0;
            in_flush  <= 1'b0;
            err_r     <= 1'b0;
            rdata_r   <= '0;
        end else begin
            st       <= st_n;
            in_flush <= flush_n;
            err_r    <= err_n;
            rdata_r  <= rdata_n;
            if (st == S_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_bus   <= req_bus_mode;
                lat_wdata <= req_wdata;
                lat_addr  <= enc_addr;
            end
        end
    end

    // output process
    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_DONE);
        err       = err_r;
        rdata     = rdata_r;
        bus_req   = 1'b0;
        bus_write = 1'b1;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (st)
            S_CTRL: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W'(CTRL_ADDR);
                bus_wdata = DATA_W'(!cur_write);
            end
            S_ADDR: begin
                bus_req   = 1'b1;
                bus_addr  = lat_addr;
                bus_wdata = cur_write ? lat_wdata : '0;
            end
            S_DATA: begin
                bus_req   = 1'b1;
                bus_write = 1'b0;
                bus_addr  = ADDR_W'(DATA_ADDR);
            end
            default: ;
        endcase
    end

    a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && req_valid && !arg_ok) |=> (done && err && !bus_req));

    a_r2_ctrl_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && req_valid && arg_ok) |=>
            (bus_req && bus_write && bus_addr == ADDR_W'(CTRL_ADDR)));

    a_r3_onehot_phy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR) |->
            (bus_addr[ADDR_W-1] && $countones(bus_addr[PHY_SHIFT+MAX_PHY:PHY_SHIFT]) == 1));

    a_r5_read_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done && bus_err && !lat_write && !in_flush) |=> (done && err));

    a_r6_fail_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err && lat_bus && !lat_write) |-> (rdata == ALL_ONES));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
    import phy_seq_pkg::*;
#(
    parameter int          PHY_W      = 5,
    parameter int          PAGE_W     = 4,
    parameter int          REG_W      = 6,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 16,
    parameter int          MAX_PHY    = 4,
    parameter int          MAX_PAGE   = 7,
    parameter int          MAX_REG    = 31,
    parameter int          PHY_SHIFT  = 9,
    parameter int          PAGE_SHIFT = 5,
    parameter logic [15:0] CTRL_ADDR  = DEF_CTRL_ADDR,
    parameter logic [15:0] DATA_ADDR  = DEF_DATA_ADDR,
    parameter logic [15:0] ENC_BASE   = DEF_ENC_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_bus_mode,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int PAGE_BITS = $clog2(MAX_PAGE + 1);
    localparam int REG_BITS  = $clog2(MAX_REG + 1);

    logic              arg_ok;
    logic [PAGE_W-1:0] eff_page;
    logic [ADDR_W-1:0] enc_addr;

    assign eff_page = req_bus_mode ? '0 : req_page;

    phy_req_check #(
        .PHY_W(PHY_W), .PAGE_W(PAGE_W), .REG_W(REG_W),
        .MAX_PHY(MAX_PHY), .MAX_PAGE(MAX_PAGE), .MAX_REG(MAX_REG)
    ) u_chk (
        .phy(req_phy), .page(req_page), .regi(req_reg),
        .page_used(!req_bus_mode), .ok(arg_ok)
    );

    phy_addr_enc #(
        .PHY_W(PHY_W), .PAGE_W(PAGE_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
        .PHY_SHIFT(PHY_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
        .PAGE_BITS(PAGE_BITS), .REG_BITS(REG_BITS), .ENC_BASE(ENC_BASE)
    ) u_enc (
        .phy(req_phy), .page(eff_page), .regi(req_reg), .addr(enc_addr)
    );

    phy_seq_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PHY_SHIFT(PHY_SHIFT),
        .MAX_PHY(MAX_PHY), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_bus_mode(req_bus_mode), .req_wdata(req_wdata),
        .arg_ok(arg_ok), .enc_addr(enc_addr),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/phy_indirect_seq_tb.sv
module phy_indirect_seq_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_bus_mode = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [3:0]  req_page = '0;
    logic [5:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic        bus_req, bus_write;
    logic [15:0] bus_addr, bus_wdata;
    logic        bus_done = 1'b0, bus_err = 1'b0;
    logic [15:0] bus_rdata = '0;

    int          n_chk = 0, n_fail = 0, cyc = 0;
    int          txn_n = 0, cnt = 0, fail_idx = -1;
    logic [15:0] resp_data = 16'h0;
    logic [15:0] log_addr [128];
    logic [15:0] log_wdata[128];
    logic        log_wr   [128];

    always #5 clk = ~clk;

    phy_indirect_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus_mode(req_bus_mode), .req_phy(req_phy), .req_page(req_page),
        .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    // model of the register master: fixed latency, logs each transaction
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_done <= 1'b0;
            bus_err  <= 1'b0;
            cnt      <= 0;
        end else if (bus_done) begin
            bus_done <= 1'b0;
            bus_err  <= 1'b0;
            cnt      <= 0;
        end else if (bus_req) begin
            if (cnt == LAT - 1) begin
                bus_done  <= 1'b1;
                bus_err   <= (txn_n == fail_idx);
                bus_rdata <= bus_write ? 16'h0 : resp_data;
                if (txn_n < 128) begin
                    log_addr[txn_n]  <= bus_addr;
                    log_wdata[txn_n] <= bus_wdata;
                    log_wr[txn_n]    <= bus_write;
                end
                txn_n <= txn_n + 1;
                cnt   <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int phy, input int page, input int regi);
        return 16'h8000 | (16'h1 << (phy + 9)) | 16'(page << 5) | 16'(regi);
    endfunction

    task automatic chk_txn(input string tag, input int idx, input logic wr,
                           input logic [15:0] addr, input logic [15:0] wd);
        chk({tag, " dir"},  32'(log_wr[idx]), 32'(wr));
        chk({tag, " addr"}, 32'(log_addr[idx]), 32'(addr));
        if (wr) chk({tag, " wdata"}, 32'(log_wdata[idx]), 32'(wd));
    endtask

    task automatic do_req(input logic wr, input logic bm, input int phy, input int page,
                          input int regi, input logic [15:0] wd,
                          output int ncyc, output int base);
        @(negedge clk);
        req_write = wr; req_bus_mode = bm;
        req_phy = 5'(phy); req_page = 4'(page); req_reg = 6'(regi); req_wdata = wd;
        req_valid = 1'b1;
        base = txn_n;
        @(negedge clk);
        req_valid = 1'b0;
        ncyc = 1;
        while (!done && ncyc < 500) begin
            @(negedge clk);
            ncyc++;
        end
    endtask

    task automatic t_reset();
        chk("R10 reset busy", 32'(busy), 0);
        chk("R10 reset done", 32'(done), 0);
        chk("R9 reset bus_req", 32'(bus_req), 0);
    endtask

    task automatic t_raw_read();
        int nc, b;
        resp_data = 16'hBEEF; fail_idx = -1;
        do_req(1'b0, 1'b0, 2, 3, 17, 16'h0, nc, b);
        chk("R10 raw read timing", 32'(nc), 13);
        chk("R4 raw read count", 32'(txn_n - b), 3);
        chk_txn("R2 raw read ctrl", b, 1'b1, 16'h8028, 16'h1);
        chk_txn("R3 raw read enc", b + 1, 1'b1, enc(2, 3, 17), 16'h0);
        chk_txn("R4 raw read data", b + 2, 1'b0, 16'h8029, 16'h0);
        chk("R4 rdata", 32'(rdata), 32'hBEEF);
        chk("R4 err", 32'(err), 0);
        chk("R10 busy at done", 32'(busy), 1);
        @(negedge clk);
        chk("R10 done pulse", 32'(done), 0);
        chk("R10 busy after", 32'(busy), 0);
    endtask

    task automatic t_raw_write();
        int nc, b;
        fail_idx = -1;
        do_req(1'b1, 1'b0, 4, 7, 31, 16'h1234, nc, b);
        chk("R7 raw write count", 32'(txn_n - b), 2);
        chk("R10 raw write timing", 32'(nc), 9);
        chk_txn("R2 raw write ctrl", b, 1'b1, 16'h8028, 16'h0);
        chk_txn("R3 raw write enc", b + 1, 1'b1, enc(4, 7, 31), 16'h1234);
        chk("R7 raw write err", 32'(err), 0);
    endtask

    task automatic t_bus_write_flush();
        int nc, b;
        resp_data = 16'h7777; fail_idx = -1;
        do_req(1'b1, 1'b1, 0, 5, 3, 16'hA5A5, nc, b);
        chk("R7 flush count", 32'(txn_n - b), 5);
        chk("R10 flush timing", 32'(nc), 21);
        chk_txn("R2 flush wr ctrl", b, 1'b1, 16'h8028, 16'h0);
        chk_txn("R8 flush wr enc page0", b + 1, 1'b1, enc(0, 0, 3), 16'hA5A5);
        chk_txn("R7 flush rd ctrl", b + 2, 1'b1, 16'h8028, 16'h1);
        chk_txn("R7 flush rd enc", b + 3, 1'b1, enc(0, 0, 3), 16'h0);
        chk_txn("R7 flush rd data", b + 4, 1'b0, 16'h8029, 16'h0);
        chk("R7 flush err", 32'(err), 0);
    endtask

    task automatic t_bus_read_page_ignored();
        int nc, b;
        resp_data = 16'h4321; fail_idx = -1;
        do_req(1'b0, 1'b1, 1, 12, 7, 16'h0, nc, b);
        chk("R8 bus read count", 32'(txn_n - b), 3);
        chk_txn("R8 bus read enc", b + 1, 1'b1, enc(1, 0, 7), 16'h0);
        chk("R8 bus read rdata", 32'(rdata), 32'h4321);
        chk("R8 bus read err", 32'(err), 0);
    endtask

    task automatic t_raw_read_err();
        int nc, b;
        resp_data = 16'h5555;
        fail_idx = txn_n + 1;
        do_req(1'b0, 1'b0, 3, 1, 2, 16'h0, nc, b);
        chk("R5 raw abort count", 32'(txn_n - b), 2);
        chk("R5 raw abort err", 32'(err), 1);
        chk("R6 raw fail rdata", 32'(rdata), 0);
        fail_idx = -1;
    endtask

    task automatic t_bus_read_err();
        int nc, b;
        resp_data = 16'h5555;
        fail_idx = txn_n + 2;
        do_req(1'b0, 1'b1, 3, 0, 9, 16'h0, nc, b);
        chk("R5 bus read count", 32'(txn_n - b), 3);
        chk("R5 bus read err", 32'(err), 1);
        chk("R6 bus fail rdata", 32'(rdata), 32'hFFFF);
        fail_idx = -1;
    endtask

    task automatic t_bus_write_err();
        int nc, b;
        fail_idx = txn_n;
        do_req(1'b1, 1'b1, 2, 0, 4, 16'h0F0F, nc, b);
        chk("R7 failed write then flush count", 32'(txn_n - b), 4);
        chk_txn("R7 flush after fail ctrl", b + 1, 1'b1, 16'h8028, 16'h1);
        chk_txn("R7 flush after fail data", b + 3, 1'b0, 16'h8029, 16'h0);
        chk("R5 write err reported", 32'(err), 1);
        fail_idx = -1;
    endtask

    task automatic t_flush_err_ignored();
        int nc, b;
        fail_idx = txn_n + 2;
        do_req(1'b1, 1'b1, 4, 0, 0, 16'hCAFE, nc, b);
        chk("R7 flush abort count", 32'(txn_n - b), 3);
        chk("R7 flush error ignored", 32'(err), 0);
        fail_idx = -1;
    endtask

    task automatic t_reject(input string tag, input logic wr, input logic bm,
                            input int phy, input int page, input int regi,
                            input logic [15:0] exp_rd);
        int nc, b;
        do_req(wr, bm, phy, page, regi, 16'h1111, nc, b);
        chk({tag, " R1 timing"}, 32'(nc), 1);
        chk({tag, " R1 no traffic"}, 32'(txn_n - b), 0);
        chk({tag, " R1 err"}, 32'(err), 1);
        chk({tag, " R1 rdata"}, 32'(rdata), 32'(exp_rd));
        repeat (3) @(negedge clk);
        chk({tag, " R1 no traffic later"}, 32'(txn_n - b), 0);
    endtask

    task automatic t_busy_ignore();
        int b, n;
        resp_data = 16'h9999; fail_idx = -1;
        @(negedge clk);
        req_write = 1'b0; req_bus_mode = 1'b0;
        req_phy = 5'd1; req_page = 4'd2; req_reg = 6'd5;
        req_valid = 1'b1; b = txn_n;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        req_write = 1'b1; req_phy = 5'd0; req_reg = 6'd1; req_wdata = 16'hDEAD;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R9 busy ignore rdata", 32'(rdata), 32'h9999);
        chk_txn("R9 busy ignore enc", b + 1, 1'b1, enc(1, 2, 5), 16'h0);
        repeat (6) @(negedge clk);
        chk("R9 busy ignore count", 32'(txn_n - b), 3);
        chk("R9 busy ignore idle", 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_raw_read();
        t_raw_write();
        t_bus_write_flush();
        t_bus_read_page_ignored();
        t_raw_read_err();
        t_bus_read_err();
        t_bus_write_err();
        t_flush_err_ignored();
        t_reject("phy5",  1'b0, 1'b0, 5, 0, 0,  16'h0);
        t_reject("page8", 1'b1, 1'b0, 0, 8, 0,  16'h0);
        t_reject("reg32", 1'b0, 1'b0, 0, 0, 32, 16'h0);
        t_reject("busrd", 1'b0, 1'b1, 7, 0, 0,  16'hFFFF);
        t_busy_ignore();
        finish_run();
    end
endmodule